// File: doc/BRIEF.md
# Timer Buffered Register Update Logic

This block is a 16-bit timer counter whose two period-defining registers, the start value and the period limit, are double-buffered. A software write always lands in a holding buffer first; the block then decides, from the counter clock state, an enhanced-mode enable, a start-value synchronization enable and the counting style, when that buffer is copied into the active register that the counter actually uses. Deferring the copy to a safe point keeps a running waveform free of truncated or stretched periods.

The counter runs either edge-aligned, counting up from the start value to the limit and then reloading the start value, or center-aligned, counting up to the limit and back down to the start value. With the start value at 0x0000 and the limit at 0xFFFF the edge-aligned counter is free-running and wraps from 0xFFFF to 0x0000. In enhanced mode a one-cycle software synchronization pulse, qualified by a synchronization-mode bit, is the only load point for buffered registers that are armed for it.

Top module: `tmr_buf_update`

## Requirements
- R1: After reset the count is 0x0000, the active start value is 0x0000 and the active limit is 0xFFFF, so the counter is free-running.
- R2: With the clock select at 2'b00 (counter stopped) the count holds, and a write to either register (select 0 = start value, 1 = limit) reaches the active register on the next clock, whatever the enhanced-mode bit is.
- R3: With the clock select non-zero and either the enhanced-mode bit or the start-value sync enable at 0, a start-value write reaches the active register on the next clock.
- R4: With the counter running, the enhanced-mode bit at 1 and the start-value sync enable at 1, a start-value write is held until a sync pulse arrives while the sync-mode bit is 1; a pulse with the sync-mode bit at 0 loads nothing.
- R5: In edge-aligned mode (up-down select 0) the running counter increments by one and, at or above the active limit, reloads the active start value.
- R6: In edge-aligned mode with the enhanced-mode bit at 0, a buffered limit becomes active on the very clock the counter passes from the limit to the start value, and not earlier.
- R7: With start value 0x0000 and limit 0xFFFF the counter wraps from 0xFFFF to 0x0000, and a buffered limit becomes active on that wrap.
- R8: In center-aligned mode (up-down select 1) the counter counts up to the limit, turns to limit minus one, counts down to the start value and turns to start value plus one.
- R9: In center-aligned mode with the enhanced-mode bit at 0, a buffered limit becomes active on the clock the counter turns from the limit down to the limit minus one, and not earlier.
- R10: With the counter running and the enhanced-mode bit at 1, a buffered limit ignores the period boundary and becomes active only on a sync pulse with the sync-mode bit at 1.
- R11: A second write before the load point replaces the buffered value; only the latest value becomes active.
- R12: A write arriving on the same clock as a load point does not take part in that load: the previously buffered value becomes active and the new value waits for the next load point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 start value, 1 limit |
| wr_data | input | 16 | Write data |
| clk_sel | input | 2 | Counter clock select, 2'b00 stops the counter |
| enh_en | input | 1 | Enhanced-mode enable |
| sync_mode | input | 1 | Qualifies the software sync pulse |
| init_sync_en | input | 1 | Arms the start value for sync loading |
| updown | input | 1 | 0 edge-aligned, 1 center-aligned |
| sw_sync | input | 1 | One-cycle software sync pulse |
| count | output | 16 | Current counter value |
| init_act | output | 16 | Active start value |
| mod_act | output | 16 | Active limit |

## Verification
The interesting collision is a fresh limit write landing on the same clock as the period boundary that releases an older buffered limit. The bench parks an earlier write in the buffer, runs the counter until it sits on the limit, then strobes a new write exactly in the boundary cycle. It judges the outcome by requiring that the older value becomes active at the reload while the newer value only appears one full period later, at the following boundary.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
    localparam int CNT_W   = 16;
    localparam int NREG    = 2;
    localparam int IDX_INI = 0;
    localparam int IDX_MOD = 1;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/tbu_counter.sv
module tbu_counter
    import tbu_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         updown_i,
    input  logic [W-1:0] init_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o,
    output logic         top_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        cnt_dir_e     dir;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_top, at_bot, span_ok;

    always_comb begin
        at_top  = (st_q.cnt >= mod_i);
        at_bot  = (st_q.cnt <= init_i);
        span_ok = (mod_i > init_i);
        st_d    = st_q;
        wrap_o  = 1'b0;
        top_o   = 1'b0;
        if (!updown_i) begin
            st_d.dir = DIR_UP;
        end
        if (run_i) begin
            if (!updown_i) begin
                if (at_top) begin
                    st_d.cnt = init_i;
                    wrap_o   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (st_q.dir == DIR_UP) begin
                if (at_top) begin
                    top_o    = 1'b1;
                    st_d.dir = DIR_DOWN;
                    st_d.cnt = span_ok ? mod_i - 1'b1 : mod_i;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (at_bot) begin
                    st_d.dir = DIR_UP;
                    st_d.cnt = span_ok ? init_i + 1'b1 : init_i;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2: a stopped counter holds its value
    a_r2_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(cnt_o));

    // R5: edge-aligned reload of the start value at the limit
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !updown_i && cnt_o >= mod_i) |=> (cnt_o == $past(init_i)));

    // R8: center-aligned turn at the top
    a_r8_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && updown_i && st_q.dir == DIR_UP && cnt_o >= mod_i && mod_i > init_i)
        |=> (cnt_o == $past(mod_i) - 1'b1));
endmodule

// File: rtl/tbu_shadow.sv
module tbu_shadow #(
    parameter int           W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         direct_i,
    input  logic         load_i,
    output logic [W-1:0] act_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
        logic         pend;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i && st_q.pend) begin
            st_d.act  = st_q.hold;
            st_d.pend = 1'b0;
        end
        if (wr_i) begin
            st_d.hold = data_i;
            if (direct_i) begin
                st_d.act  = data_i;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hold: RST, act: RST, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o  = st_q.act;
    assign pend_o = st_q.pend;

    // R2: immediate-path writes land on the next clock
    a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && direct_i) |=> (act_o == $past(data_i)));

    // R11: a deferred write always leaves a pending load with its value buffered
    a_r11_latest: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !direct_i) |=> (pend_o && st_q.hold == $past(data_i)));

    // R12: a load never takes the value written in the same cycle
    a_r12_old_value: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && st_q.pend && wr_i && !direct_i) |=> (act_o == $past(st_q.hold)));
endmodule

// File: rtl/tmr_buf_update.sv
module tmr_buf_update
    import tbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       clk_sel,
    input  logic             enh_en,
    input  logic             sync_mode,
    input  logic             init_sync_en,
    input  logic             updown,
    input  logic             sw_sync,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] init_act,
    output logic [CNT_W-1:0] mod_act
);
    localparam logic [CNT_W-1:0] INI_RST = '0;
    localparam logic [CNT_W-1:0] MOD_RST = '1;

    logic             run;
    logic             sync_evt;
    logic             ini_armed;
    logic             wrap_evt, top_evt, mod_bnd;
    logic [NREG-1:0]  wr_vec, direct_vec, load_vec, pend_vec;
    logic [CNT_W-1:0] act_vec [NREG];

    always_comb begin
        run       = (clk_sel != 2'b00);
        sync_evt  = sw_sync && sync_mode;
        ini_armed = enh_en && init_sync_en;
        mod_bnd   = updown ? top_evt : wrap_evt;

        wr_vec[IDX_INI]     = wr_en && !wr_sel;
        direct_vec[IDX_INI] = !run || !ini_armed;
        load_vec[IDX_INI]   = sync_evt && ini_armed;

        wr_vec[IDX_MOD]     = wr_en && wr_sel;
        direct_vec[IDX_MOD] = !run;
        load_vec[IDX_MOD]   = run && (enh_en ? sync_evt : mod_bnd);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_shadow
        tbu_shadow #(
            .W   (CNT_W),
            .RST ((g == IDX_MOD) ? MOD_RST : INI_RST)
        ) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr_vec[g]),
            .data_i   (wr_data),
            .direct_i (direct_vec[g]),
            .load_i   (load_vec[g]),
            .act_o    (act_vec[g]),
            .pend_o   (pend_vec[g])
        );
    end

    assign init_act = act_vec[IDX_INI];
    assign mod_act  = act_vec[IDX_MOD];

    tbu_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .updown_i (updown),
        .init_i   (init_act),
        .mod_i    (mod_act),
        .cnt_o    (count),
        .wrap_o   (wrap_evt),
        .top_o    (top_evt)
    );

    // R3: unarmed start-value writes take effect on the next clock
    a_r3_ini_next: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && !wr_sel && !ini_armed) |=> (init_act == $past(wr_data)));

    // R4: an armed start value moves only on a qualified sync pulse
    a_r4_ini_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ini_armed && !sync_evt) |=> $stable(init_act));

    // R6: the limit stays put between period boundaries
    a_r6_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !enh_en && !updown && count < mod_act) |=> $stable(mod_act));

    // R9: in center-aligned mode the limit moves only at the top turn
    a_r9_mod_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !enh_en && updown && !top_evt) |=> $stable(mod_act));

    // R10: enhanced mode ignores the period boundary for the limit
    a_r10_mod_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enh_en && !sync_evt) |=> $stable(mod_act));
endmodule

// File: tb/tmr_buf_update_tb.sv
module tmr_buf_update_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  clk_sel = 2'b00;
    logic        enh_en = 1'b0;
    logic        sync_mode = 1'b0;
    logic        init_sync_en = 1'b0;
    logic        updown = 1'b0;
    logic        sw_sync = 1'b0;
    logic [15:0] count, init_act, mod_act;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_buf_update u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clk_sel(clk_sel), .enh_en(enh_en), .sync_mode(sync_mode),
        .init_sync_en(init_sync_en), .updown(updown), .sw_sync(sw_sync),
        .count(count), .init_act(init_act), .mod_act(mod_act)
    );

    typedef struct packed {
        logic        sel;
        logic [15:0] data;
        logic [15:0] e_ini;
        logic [15:0] e_mod;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 16'h0003, 16'h0003, 16'hFFFF},
        '{1'b1, 16'h0010, 16'h0003, 16'h0010},
        '{1'b0, 16'h0005, 16'h0005, 16'h0010},
        '{1'b1, 16'h0008, 16'h0005, 16'h0008},
        '{1'b0, 16'h0002, 16'h0002, 16'h0008},
        '{1'b1, 16'h000A, 16'h0002, 16'h000A}
    };

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input logic [15:0] v);
        for (int i = 0; i < 70000 && count != v; i++) tick();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "count", count, 16'h0000);
        chk("R1", "init", init_act, 16'h0000);
        chk("R1", "mod", mod_act, 16'hFFFF);

        // R2: stopped-clock writes, table driven
        for (int k = 0; k < 6; k++) begin
            wr(VECS[k].sel, VECS[k].data);
            chk("R2", "init", init_act, VECS[k].e_ini);
            chk("R2", "mod", mod_act, VECS[k].e_mod);
            chk("R2", "count hold", count, 16'h0000);
        end

        // R6 / R11: edge-aligned deferred limit, double write
        clk_sel = 2'b01;
        wait_count(16'd4);
        wr(1'b1, 16'd6);
        chk("R6", "count", count, 16'd5);
        chk("R6", "mod early", mod_act, 16'd10);
        wr(1'b1, 16'd7);
        wait_count(16'd10);
        chk("R6", "mod at limit", mod_act, 16'd10);
        tick();
        chk("R5", "reload", count, 16'd2);
        chk("R11", "latest mod", mod_act, 16'd7);
        wait_count(16'd7);
        tick();
        chk("R5", "wrap new limit", count, 16'd2);

        // R3: start value while running, unarmed
        wr(1'b0, 16'd1);
        chk("R3", "init", init_act, 16'd1);
        wait_count(16'd7);
        tick();
        chk("R5", "reload new init", count, 16'd1);

        // R12: write on the boundary cycle
        wr(1'b1, 16'd9);
        wait_count(16'd7);
        wr(1'b1, 16'd12);
        chk("R12", "count", count, 16'd1);
        chk("R12", "old buffered mod", mod_act, 16'd9);
        wait_count(16'd9);
        tick();
        chk("R12", "newer mod later", mod_act, 16'd12);

        // R7: free-running wrap
        clk_sel = 2'b00;
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'hFFFF);
        chk("R2", "count held", count, 16'd1);
        chk("R2", "mod", mod_act, 16'hFFFF);
        clk_sel = 2'b11;
        wait_count(16'hFFF0);
        wr(1'b1, 16'h0100);
        wait_count(16'hFFFF);
        chk("R7", "mod before wrap", mod_act, 16'hFFFF);
        tick();
        chk("R7", "wrap", count, 16'h0000);
        chk("R7", "mod at wrap", mod_act, 16'h0100);
        clk_sel = 2'b00;

        // R8 / R9: center-aligned
        wr(1'b0, 16'd2);
        wr(1'b1, 16'd6);
        updown = 1'b1;
        clk_sel = 2'b10;
        wait_count(16'd6);
        tick();
        chk("R8", "top turn", count, 16'd5);
        wait_count(16'd2);
        tick();
        chk("R8", "bottom turn", count, 16'd3);
        wr(1'b1, 16'd9);
        chk("R9", "mod early", mod_act, 16'd6);
        wait_count(16'd6);
        chk("R9", "mod at top", mod_act, 16'd6);
        tick();
        chk("R9", "turn count", count, 16'd5);
        chk("R9", "mod loaded", mod_act, 16'd9);
        wait_count(16'd2);
        wait_count(16'd9);
        tick();
        chk("R8", "new top turn", count, 16'd8);

        // R10: enhanced mode limit via sync only
        updown = 1'b0; enh_en = 1'b1; sync_mode = 1'b1;
        wr(1'b1, 16'd5);
        chk("R5", "count up", count, 16'd9);
        tick();
        chk("R10", "count reload", count, 16'd2);
        chk("R10", "mod not at boundary", mod_act, 16'd9);
        sw_sync = 1'b1;
        tick();
        sw_sync = 1'b0;
        chk("R10", "mod on sync", mod_act, 16'd5);

        // R4: armed start value
        init_sync_en = 1'b1;
        wr(1'b0, 16'd3);
        chk("R4", "init held", init_act, 16'd2);
        sync_mode = 1'b0; sw_sync = 1'b1;
        tick();
        sw_sync = 1'b0;
        chk("R4", "unqualified pulse", init_act, 16'd2);
        sync_mode = 1'b1; sw_sync = 1'b1;
        tick();
        sw_sync = 1'b0;
        chk("R4", "init on sync", init_act, 16'd3);

        done = 1'b1;
        summary();
    end
endmodule